// File: doc/BRIEF.md
# Two-Vector Delay Test Launch/Capture Sequencer

This block drives a plain mux-D scan chain, one that has no hold latches, through a complete two-pattern delay test. It produces three kinds of signal. The first is the scan-enable level. The second is a clock-enable pulse train that the chain's flops use on a single fast reference clock. The third is a set of one-cycle strobes that mark the application of the first and second primary-input patterns, the capture edge and the end of the test. The first pattern is loaded with slow shift pulses. The second pattern is then launched, and the response is captured exactly one reference cycle after the launch. The captured result is shifted out at the slow rate.

The second pattern can come from two sources, chosen when the test starts. In shift-launch mode, the launch edge is one more scan shift, and scan enable stays high. In functional-launch mode, scan enable drops one slow period before the launch edge, so that the launch edge loads the functional response to the first pattern. In both modes, only the launch-to-capture interval runs at the rated speed. Every other edge sits on a slow grid whose period is set by a divide ratio.

Top module: `lc_seq_ctrl`

## Requirements
- R1: During and after reset, and while idle with no start, every output is low.
- R2: A start accepted at reference edge e0 opens the load phase. The k-th shift pulse (k = 1..N, where N is the captured chain length) drives clk_en_o high for one cycle, k*D-1 cycles after e0, with scan_en_o high throughout the phase.
- R3: The slow period D is the captured divide value. A divide value below 2 acts as 2, and a chain length of 0 acts as 1.
- R4: With launch_mode_i = 0 (shift launch), the launch pulse comes one slow period after the last load pulse, and scan_en_o stays high through it.
- R5: With launch_mode_i = 1 (functional launch), scan_en_o is low from the cycle after the last load pulse, through the launch pulse and the capture pulse.
- R6: The capture pulse follows the launch pulse by exactly one cycle, with clk_en_o and capture_o high and scan_en_o low.
- R7: The unload phase emits N shift pulses on the same slow grid, with the first one slow period after the launch pulse, and scan_en_o high from the cycle after capture.
- R8: done_o is high for exactly one cycle, the cycle after the last unload pulse, and the block is then idle.
- R9: pi_v1_o pulses together with the last load pulse, and pi_v2_o pulses together with the launch pulse.
- R10: start_i is ignored from the accepting edge until the block is idle again, including the done cycle.
- R11: The mode, the chain length and the divide value are sampled only at the accepting edge. Changes to them during a test have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (rated period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a test (taken only when idle) |
| launch_mode_i | input | 1 | 0 = launch by extra shift, 1 = launch by functional clock |
| chain_len_i | input | LEN_W | Scan chain length in flops |
| slow_div_i | input | DIV_W | Slow period in reference cycles |
| scan_en_o | output | 1 | Scan-enable level for the chain |
| clk_en_o | output | 1 | Clock-enable pulse for the chain flops |
| capture_o | output | 1 | Marks the rated-speed capture pulse |
| pi_v1_o | output | 1 | Apply the first primary-input pattern |
| pi_v2_o | output | 1 | Apply the second primary-input pattern |
| done_o | output | 1 | Result fully shifted out |

## Verification
The bench builds the block with LEN_W = 6 and DIV_W = 3. These widths keep the table of runs short, while still covering chain lengths from 0 to 5 and divide values from 1 to 4. They also allow a mid-test write of an out-of-range length and divide value, so the clamping to 2 and 1 and the sampling at the start edge can both be observed. Each run is compared cycle by cycle against a timeline derived from N and D. This exposes an off-by-one in the launch or capture spacing, a wrong scan-enable level in either launch mode, and a start request that is honoured while the block is busy.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_CAPT   = 3'd3,
    ST_UNLOAD = 3'd4,
    ST_DONE   = 3'd5
  } lc_state_e;

  localparam logic LAUNCH_SHIFT = 1'b0;
  localparam logic LAUNCH_FUNC  = 1'b1;
endpackage

// File: rtl/lc_tick_gen.sv
// Slow-grid tick: one pulse every D reference cycles while running.
module lc_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] rel_q, rel_d;
  logic [DIV_W-1:0] rel_in;

  always_comb begin
    rel_in = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);
    tick_o = run_i && (cnt_q == '0);
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    if (restart_i) begin
      cnt_d = rel_in;
      rel_d = rel_in;
    end else if (run_i) begin
      cnt_d = tick_o ? rel_q : cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end
endmodule

// File: rtl/lc_shift_cnt.sv
// Counts shift pulses of one phase; the length is captured at start.
module lc_shift_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             reload_i,
  input  logic             dec_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] len_in;

  always_comb begin
    len_in = (len_i == '0) ? LEN_W'(1) : len_i;
    last_o = (cnt_q == LEN_W'(1));
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (start_i) begin
      cnt_d = len_in;
      len_d = len_in;
    end else if (reload_i) begin
      cnt_d = len_q;
    end else if (dec_i) begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/lc_seq_ctrl.sv
module lc_seq_ctrl
  import lc_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             launch_mode_i,
  input  logic [LEN_W-1:0] chain_len_i,
  input  logic [DIV_W-1:0] slow_div_i,
  output logic             scan_en_o,
  output logic             clk_en_o,
  output logic             capture_o,
  output logic             pi_v1_o,
  output logic             pi_v2_o,
  output logic             done_o
);
  lc_state_e st_q, st_d;
  logic      mode_q, mode_d;
  logic      accept, run, tick, last;
  logic      in_shift;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign in_shift = (st_q == ST_LOAD) || (st_q == ST_UNLOAD);
  assign run      = (st_q == ST_LOAD) || (st_q == ST_LAUNCH) ||
                    (st_q == ST_CAPT) || (st_q == ST_UNLOAD);

  lc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .run_i     (run),
    .div_i     (slow_div_i),
    .tick_o    (tick)
  );

  lc_shift_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept),
    .reload_i ((st_q == ST_LAUNCH) && tick),
    .dec_i    (in_shift && tick),
    .len_i    (chain_len_i),
    .last_o   (last)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_LOAD;
        mode_d = launch_mode_i;
      end
      ST_LOAD:   if (tick && last) st_d = ST_LAUNCH;
      ST_LAUNCH: if (tick) st_d = ST_CAPT;
      ST_CAPT:   st_d = ST_UNLOAD;
      ST_UNLOAD: if (tick && last) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= LAUNCH_SHIFT;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
    end
  end

  // Output decode
  always_comb begin
    scan_en_o = in_shift || ((st_q == ST_LAUNCH) && (mode_q == LAUNCH_SHIFT));
    clk_en_o  = (run && tick) || (st_q == ST_CAPT);
    capture_o = (st_q == ST_CAPT);
    pi_v1_o   = (st_q == ST_LOAD) && tick && last;
    pi_v2_o   = (st_q == ST_LAUNCH) && tick;
    done_o    = (st_q == ST_DONE);
  end
endmodule

// File: rtl/lc_seq_ctrl_chk.sv
module lc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic scan_en_o,
  input logic clk_en_o,
  input logic capture_o,
  input logic pi_v1_o,
  input logic pi_v2_o,
  input logic done_o,
  input logic launch_fn_q
);
  assert_capture_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pi_v2_o |=> capture_o);

  assert_capture_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> (clk_en_o && !scan_en_o));

  assert_shift_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_v2_o && !launch_fn_q) |-> scan_en_o);

  assert_func_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_v2_o && launch_fn_q) |-> !scan_en_o);

  assert_unload_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> scan_en_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_v1_on_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pi_v1_o |-> (clk_en_o && scan_en_o));

  assert_strobes_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({capture_o, done_o, pi_v1_o, pi_v2_o}));
endmodule

bind lc_seq_ctrl lc_seq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_en_o   (scan_en_o),
  .clk_en_o    (clk_en_o),
  .capture_o   (capture_o),
  .pi_v1_o     (pi_v1_o),
  .pi_v2_o     (pi_v2_o),
  .done_o      (done_o),
  .launch_fn_q (mode_q)
);

// File: tb/lc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module lc_seq_ctrl_tb;
  localparam int LEN_W = 6;
  localparam int DIV_W = 3;
  localparam int NV    = 6;
  // columns: mode, chain length, divide, expected done cycle, start-inject cycle
  localparam int TBL [NV][5] = '{
    '{0, 3, 3, 21, 5},
    '{1, 3, 3, 21, 21},
    '{0, 1, 2,  6, 2},
    '{1, 2, 4, 20, 13},
    '{0, 0, 1,  6, 6},
    '{1, 5, 2, 22, 9}
  };

  logic clk, rst_n, start_i, launch_mode_i;
  logic [LEN_W-1:0] chain_len_i;
  logic [DIV_W-1:0] slow_div_i;
  logic scan_en_o, clk_en_o, capture_o, pi_v1_o, pi_v2_o, done_o;
  int n_chk, n_fail;

  lc_seq_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .launch_mode_i(launch_mode_i),
    .chain_len_i(chain_len_i), .slow_div_i(slow_div_i),
    .scan_en_o(scan_en_o), .clk_en_o(clk_en_o), .capture_o(capture_o),
    .pi_v1_o(pi_v1_o), .pi_v2_o(pi_v2_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Expected {scan, clk_en, capture, done, v1, v2} at sample j after the accepting edge
  function automatic logic [5:0] model(input int j, input int m, input int n, input int d);
    int l, la, c, ue, dn;
    logic s, k;
    l = n * d; la = (n + 1) * d - 1; c = (n + 1) * d; ue = (2 * n + 1) * d - 1; dn = ue + 1;
    if (j < 0 || j > dn) return 6'b0;
    s = (j < l) || (j >= l && j <= la && m == 0) || (j > c && j <= ue);
    k = (j <= ue && (j % d) == d - 1) || (j == c);
    return {s, k, j == c, j == dn, j == l - 1, j == la};
  endfunction

  task automatic run_vec(input int m, input int len, input int div, input int exp_done,
                         input int inj);
    int n, d, done_at;
    int err[6];
    logic [5:0] act, exp;
    n = (len == 0) ? 1 : len;
    d = (div < 2) ? 2 : div;
    foreach (err[i]) err[i] = 0;
    done_at = -1;
    @(negedge clk);
    launch_mode_i = m[0]; chain_len_i = LEN_W'(len); slow_div_i = DIV_W'(div); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R11: disturb the configuration inputs once the test is running
    launch_mode_i = ~m[0]; chain_len_i = LEN_W'(40); slow_div_i = DIV_W'(7);
    for (int j = 0; j <= exp_done + 3; j++) begin
      act = {scan_en_o, clk_en_o, capture_o, done_o, pi_v1_o, pi_v2_o};
      exp = model(j, m, n, d);
      for (int b = 0; b < 6; b++) if (act[b] != exp[b]) err[b]++;
      if (done_o && done_at < 0) done_at = j;
      start_i = (j == inj); // R10: request while busy must be ignored
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(err[5] == 0, "R2 R4 R5 R7 R11 scan_en mismatches", err[5], 0);
    chk(err[4] == 0, "R3 R6 R7 R10 clk_en mismatches", err[4], 0);
    chk(err[3] == 0, "R6 capture mismatches", err[3], 0);
    chk(err[2] == 0, "R8 R10 done mismatches", err[2], 0);
    chk(err[1] + err[0] == 0, "R9 strobe mismatches", err[1] + err[0], 0);
    chk(done_at == exp_done, "R8 R3 done cycle", done_at, exp_done);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; launch_mode_i = 1'b0;
    chain_len_i = '0; slow_div_i = '0;
    #1;
    chk({scan_en_o, clk_en_o, capture_o, pi_v1_o, pi_v2_o, done_o} == 6'b0,
        "R1 outputs in reset", int'({scan_en_o, clk_en_o, capture_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin : idle_chk
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        seen += int'(clk_en_o) + int'(scan_en_o) + int'(done_o) + int'(capture_o);
      end
      chk(seen == 0, "R1 idle outputs", seen, 0);
    end

    for (int v = 0; v < NV; v++)
      run_vec(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4]);

    // R1: reset in the middle of a test
    @(negedge clk);
    launch_mode_i = 1'b0; chain_len_i = LEN_W'(4); slow_div_i = DIV_W'(3); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({scan_en_o, clk_en_o, capture_o, done_o} == 4'b0, "R1 mid-test reset",
        int'({scan_en_o, clk_en_o, capture_o, done_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(0, 2, 2, 10, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule